// File: doc/BRIEF.md
# I2C Master Burst Sequencer

This block turns one host write of a control byte into a short burst of byte transfers on an I2C bus. The bus itself is driven by a separate byte-level engine that accepts four commands: address phase (with a 7-bit target and a direction), send one byte, receive one byte, and stop. Each command is presented on a valid/done handshake, and the engine returns an acknowledge flag with the done pulse. The sequencer decides which commands to issue and in what order. It takes data to send from a four-byte transmit buffer and places received bytes into a four-byte receive buffer.

The control byte selects the direction, the burst length (one to four bytes), and whether a stop follows each byte. Two options control the stop: the hold-bus option keeps the bus between bytes and bursts, and the stop-each option forces a stop after every byte. An abort command frees a bus that the sequencer still holds. The block records an error flag and a sticky abort flag. It also records the number of bytes that completed, and it reports whether the bus is held.

Top module: `i2c_burst_seq`

## Requirements
- R1: After reset, `busy` is 0, `ctrl_q` is 0x00, `xfer_cnt` is 0, `err` is 0, `cmd_valid` is 0 and `ext_status` is 0x40.
- R2: A control write while idle stores bits [7:1] in `ctrl_q`. Bit 0 (go) is never stored and always reads as 0. The control bit positions are: 0 go, 1 read, 2 hold-bus, 3 stop-each, [5:4] byte count minus one, 6 wide-address request, 7 abort.
- R3: Every address phase carries `addr_reg[7:1]` as the target and control bit 1 as `cmd_rnw`. Control bit 6 changes nothing.
- R4: Each byte is preceded by an address phase (`cmd_op`=0) only if the bus is not held. A write sends transmit byte i (`tx_data[8i+7:8i]`) with `cmd_op`=1. A read issues `cmd_op`=2 and stores `cmd_rdata` into `rx_data[8i+7:8i]`. While `cmd_valid` is high and `cmd_done` is low, the command does not change.
- R5: A stop (`cmd_op`=3) follows a byte when stop-each is 1 or hold-bus is 0. Otherwise the bus stays held after the byte.
- R6: A burst moves control bits [5:4] plus one bytes when no NACK occurs.
- R7: A NACK on an address phase sets `err` and the sticky abort flag, and ends the burst with no further command.
- R8: A NACK on a data byte sets `err` and the abort flag, and ends the burst with no further command and the bus still held.
- R9: An acknowledged address phase clears `err`. The abort flag stays set until reset.
- R10: When `busy` falls after a burst, `xfer_cnt` holds the number of bytes that completed, and `burst_done` pulsed for one cycle just before.
- R11: A control write with bit 7 set while the bus is held issues exactly one stop and no transfer, even if bit 0 is also set. With bit 7 set on a free bus and bit 0 clear, no command is issued.
- R12: A control write while `busy` is 1 is ignored: `ctrl_q` is unchanged and the running burst is unaffected.
- R13: `ext_status` is 0x40 with the bus free and 0x50 with the bus held, with bit 0 carrying the abort flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 8 | Control write value |
| addr_reg | input | 8 | Target address register; bits [7:1] are the 7-bit target |
| tx_data | input | 8*BUF_BYTES | Transmit buffer, byte i at [8i+7:8i] |
| cmd_valid | output | 1 | Command request to the byte engine |
| cmd_op | output | 2 | 0 address, 1 send, 2 receive, 3 stop |
| cmd_addr | output | 7 | Target address for an address phase |
| cmd_rnw | output | 1 | Direction for an address phase (1 = read) |
| cmd_wdata | output | 8 | Byte to send |
| cmd_done | input | 1 | Command complete pulse |
| cmd_ack | input | 1 | Acknowledge received, valid with cmd_done |
| cmd_rdata | input | 8 | Received byte, valid with cmd_done |
| busy | output | 1 | Burst or abort stop in progress |
| burst_done | output | 1 | One-cycle pulse at the end of a burst |
| ctrl_q | output | 8 | Control read-back |
| err | output | 1 | Error flag |
| ext_status | output | 8 | Bus state 0x40/0x50, bit 0 abort flag |
| xfer_cnt | output | CNT_W | Bytes completed in the last burst |
| rx_data | output | 8*BUF_BYTES | Receive buffer |

## Verification
A control write sampled on one edge makes `busy` and the first `cmd_valid` visible on the next edge. Each `cmd_done` moves the sequence on one edge later. `xfer_cnt` updates on the same edge on which `busy` falls. `err` and the abort flag are updated on the edge that takes the `cmd_done` carrying the NACK. The bench drives all inputs and samples all outputs on the falling edge. After each stimulus it waits until `busy` is low, with a bounded loop, and only then reads the count and status. A modelled byte engine logs every command at the moment it answers, and the bench compares that log entry by entry with a sequence it derives from the control byte.

// File: rtl/i2cs_pkg.sv
// Shared encodings for the I2C burst sequencer: command opcodes,
// sequencer states and control-byte bit positions.
package i2cs_pkg;
    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_STOP,
        ST_ABORT,
        ST_FIN
    } seq_st_e;

    localparam int CB_GO    = 0;
    localparam int CB_READ  = 1;
    localparam int CB_HOLD  = 2;
    localparam int CB_STOPE = 3;
    localparam int CB_LEN   = 4;   // two-bit field [5:4]
    localparam int CB_ABORT = 7;
endpackage

// File: rtl/i2cs_ctrl_reg.sv
// Control register of the burst sequencer.
// Stores a host control write while the sequencer is idle, never keeps the
// go bit, and decodes launch and abort requests from the written value.
// Assumes ctrl_wr is a single-cycle strobe.
module i2cs_ctrl_reg
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    input  logic       busy,
    input  logic       bus_held,
    output logic [7:0] ctrl_q,
    output logic       launch,
    output logic       abort_req
);
    logic accept;

    // A write counts only while no burst is running.
    assign accept    = ctrl_wr && !busy;
    assign abort_req = accept && ctrl_wdata[CB_ABORT] && bus_held;
    assign launch    = accept && ctrl_wdata[CB_GO] && !abort_req;

    // Hold the control byte; bit 0 is always dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 8'h00;
        end else if (accept) begin
            ctrl_q <= {ctrl_wdata[7:1], 1'b0};
        end
    end

    a_r12_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && busy) |=> $stable(ctrl_q));
endmodule

// File: rtl/i2cs_engine.sv
// Sequencing engine: walks through the bytes of a burst, issuing address,
// data and stop commands to the byte-level bus engine, and tracks bus
// ownership, error and abort flags, and the completed-byte count.
// Assumes cmd_done is a one-cycle pulse answering the current command.
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int BUF_BYTES = 4,
    localparam int IDX_W = $clog2(BUF_BYTES),
    localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   launch,
    input  logic                   abort_req,
    input  logic [7:0]             ctrl_q,
    input  logic [8*BUF_BYTES-1:0] tx_data,
    input  logic [7:0]             addr_reg,
    output logic                   cmd_valid,
    output logic [1:0]             cmd_op,
    output logic [6:0]             cmd_addr,
    output logic                   cmd_rnw,
    output logic [7:0]             cmd_wdata,
    input  logic                   cmd_done,
    input  logic                   cmd_ack,
    input  logic [7:0]             cmd_rdata,
    output logic                   busy,
    output logic                   burst_done,
    output logic                   bus_held,
    output logic                   err,
    output logic                   abrt,
    output logic [CNT_W-1:0]       xfer_cnt,
    output logic [8*BUF_BYTES-1:0] rx_data
);
    seq_st_e          st;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] moved;
    logic             last_byte;
    logic             stop_each;

    assign last_byte = (idx == IDX_W'(ctrl_q[CB_LEN +: 2]));
    assign stop_each = ctrl_q[CB_STOPE] || !ctrl_q[CB_HOLD];

    // Drive the command presented to the byte engine from the state.
    always_comb begin
        cmd_valid = (st == ST_ADDR) || (st == ST_DATA) || (st == ST_STOP) || (st == ST_ABORT);
        unique case (st)
            ST_ADDR: cmd_op = OP_ADDR;
            ST_DATA: cmd_op = ctrl_q[CB_READ] ? OP_RECV : OP_SEND;
            default: cmd_op = OP_STOP;
        endcase
        cmd_addr  = addr_reg[7:1];
        cmd_rnw   = ctrl_q[CB_READ];
        cmd_wdata = tx_data[8*idx +: 8];
    end

    assign busy       = (st != ST_IDLE);
    assign burst_done = (st == ST_FIN);

    // Advance the burst one command at a time and keep flags and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            idx      <= '0;
            moved    <= '0;
            bus_held <= 1'b0;
            err      <= 1'b0;
            abrt     <= 1'b0;
            xfer_cnt <= '0;
            rx_data  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (abort_req) begin
                        st <= ST_ABORT;
                    end else if (launch) begin
                        idx   <= '0;
                        moved <= '0;
                        st    <= bus_held ? ST_DATA : ST_ADDR;
                    end
                end
                ST_ADDR: if (cmd_done) begin
                    if (cmd_ack) begin
                        err      <= 1'b0;
                        bus_held <= 1'b1;
                        st       <= ST_DATA;
                    end else begin
                        err  <= 1'b1;
                        abrt <= 1'b1;
                        st   <= ST_FIN;
                    end
                end
                ST_DATA: if (cmd_done) begin
                    if (cmd_ack) begin
                        if (ctrl_q[CB_READ]) rx_data[8*idx +: 8] <= cmd_rdata;
                        moved <= moved + CNT_W'(1);
                        if (stop_each) begin
                            st <= ST_STOP;
                        end else if (last_byte) begin
                            st <= ST_FIN;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end else begin
                        err  <= 1'b1;
                        abrt <= 1'b1;
                        st   <= ST_FIN;
                    end
                end
                ST_STOP: if (cmd_done) begin
                    bus_held <= 1'b0;
                    if (last_byte) begin
                        st <= ST_FIN;
                    end else begin
                        idx <= idx + IDX_W'(1);
                        st  <= ST_ADDR;
                    end
                end
                ST_ABORT: if (cmd_done) begin
                    bus_held <= 1'b0;
                    st       <= ST_IDLE;
                end
                ST_FIN: begin
                    xfer_cnt <= moved;
                    st       <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    a_r4_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op)));
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cnt <= CNT_W'(BUF_BYTES));
endmodule

// File: rtl/i2c_burst_seq.sv
// Top of the I2C burst sequencer: joins the control register and the
// sequencing engine and forms the extended status byte.
// Assumes a byte-level bus engine answers each command with cmd_done.
module i2c_burst_seq
    import i2cs_pkg::*;
#(
    parameter int BUF_BYTES = 4,
    localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctrl_wr,
    input  logic [7:0]             ctrl_wdata,
    input  logic [7:0]             addr_reg,
    input  logic [8*BUF_BYTES-1:0] tx_data,
    output logic                   cmd_valid,
    output logic [1:0]             cmd_op,
    output logic [6:0]             cmd_addr,
    output logic                   cmd_rnw,
    output logic [7:0]             cmd_wdata,
    input  logic                   cmd_done,
    input  logic                   cmd_ack,
    input  logic [7:0]             cmd_rdata,
    output logic                   busy,
    output logic                   burst_done,
    output logic [7:0]             ctrl_q,
    output logic                   err,
    output logic [7:0]             ext_status,
    output logic [CNT_W-1:0]       xfer_cnt,
    output logic [8*BUF_BYTES-1:0] rx_data
);
    logic launch, abort_req, bus_held, abrt;

    i2cs_ctrl_reg i_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .busy(busy), .bus_held(bus_held), .ctrl_q(ctrl_q),
        .launch(launch), .abort_req(abort_req)
    );

    i2cs_engine #(.BUF_BYTES(BUF_BYTES)) i_eng (
        .clk(clk), .rst_n(rst_n), .launch(launch), .abort_req(abort_req),
        .ctrl_q(ctrl_q), .tx_data(tx_data), .addr_reg(addr_reg),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_rnw(cmd_rnw), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done),
        .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata), .busy(busy),
        .burst_done(burst_done), .bus_held(bus_held), .err(err), .abrt(abrt),
        .xfer_cnt(xfer_cnt), .rx_data(rx_data)
    );

    // Bus state nibble 4 (free) or 5 (held), abort flag in bit 0.
    assign ext_status = {3'b010, bus_held, 3'b000, abrt};

    a_r7_addr_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_done && !cmd_ack && cmd_op == OP_ADDR) |=> (err && ext_status[0]));
    a_r8_data_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_done && !cmd_ack && (cmd_op == OP_SEND || cmd_op == OP_RECV))
        |=> (err && ext_status[0] && ext_status[4]));
    a_r9_addr_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_done && cmd_ack && cmd_op == OP_ADDR) |=> (!err && ext_status[4]));
    a_r5_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_done && cmd_op == OP_STOP) |=> !ext_status[4]);
endmodule

// File: tb/test_i2c_burst_seq.sv
module test_i2c_burst_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = 8'h00;
    logic [7:0]  addr_reg = 8'hA4;
    logic [31:0] tx_data = 32'h44332211;
    logic        cmd_valid, cmd_rnw, busy, burst_done, err;
    logic [1:0]  cmd_op;
    logic [6:0]  cmd_addr;
    logic [7:0]  cmd_wdata, ctrl_q, ext_status;
    logic        cmd_done = 1'b0;
    logic        cmd_ack = 1'b1;
    logic [7:0]  cmd_rdata = 8'h00;
    logic [2:0]  xfer_cnt;
    logic [31:0] rx_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lg[0:63];
    int lg_n = 0;
    int ex[0:63];
    int ex_n = 0;
    int nack_at = -1;
    int wait_q = 0;
    bit done_q = 0;
    int seen_done = 0;

    i2c_burst_seq i_i2c_burst_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .addr_reg(addr_reg), .tx_data(tx_data), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_rnw(cmd_rnw),
        .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_ack(cmd_ack),
        .cmd_rdata(cmd_rdata), .busy(busy), .burst_done(burst_done),
        .ctrl_q(ctrl_q), .err(err), .ext_status(ext_status),
        .xfer_cnt(xfer_cnt), .rx_data(rx_data)
    );

    always #4 clk = ~clk;

    // Byte-engine model: answers each command two cycles after it appears, logs it.
    always @(negedge clk) begin
        cycles++;
        if (burst_done) seen_done++;
        if (done_q) begin
            cmd_done = 1'b0;
            done_q   = 1'b0;
        end else if (cmd_valid) begin
            if (wait_q == 2) begin
                if (cmd_op == 2'd0)      lg[lg_n] = {cmd_addr, cmd_rnw};
                else if (cmd_op == 2'd1) lg[lg_n] = 32'h100 | cmd_wdata;
                else                     lg[lg_n] = int'(cmd_op) << 8;
                cmd_ack   = (lg_n != nack_at);
                cmd_rdata = 8'h30 + 8'(lg_n);
                if (lg_n < 63) lg_n++;
                cmd_done = 1'b1;
                done_q   = 1'b1;
                wait_q   = 0;
            end else begin
                wait_q++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int v);
        ex[ex_n] = v;
        ex_n++;
    endtask

    task automatic clear_log();
        lg_n = 0;
        ex_n = 0;
        seen_done = 0;
    endtask

    task automatic compare_log(input string req);
        chk({req, " command count"}, lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++) chk({req, " command"}, lg[i], ex[i]);
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_wdata = v;
        ctrl_wr    = 1'b1;
        @(negedge clk);
        ctrl_wr    = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 ctrl_q", ctrl_q, 0);
        chk("R1 xfer_cnt", xfer_cnt, 0);
        chk("R1 err", err, 0);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R13 ext free", ext_status, 8'h40);
    endtask

    task automatic t_write_two();
        clear_log();
        write_ctrl(8'h11);
        wait_idle();
        for (int b = 0; b < 2; b++) begin
            push(8'hA4); push(32'h100 | (8'h11 * (b + 1))); push(32'h300);
        end
        compare_log("R4 R5 write two");
        chk("R6 R10 count", xfer_cnt, 2);
        chk("R10 done pulse", seen_done, 1);
        chk("R2 go bit dropped", ctrl_q, 8'h10);
        chk("R13 ext free", ext_status, 8'h40);
    endtask

    task automatic t_read_hold();
        clear_log();
        write_ctrl(8'h77);
        wait_idle();
        push(8'hA5);
        for (int b = 0; b < 4; b++) push(32'h200);
        compare_log("R3 R5 read held");
        chk("R6 count four", xfer_cnt, 4);
        chk("R4 rx bytes", rx_data, 32'h34333231);
        chk("R13 ext held", ext_status, 8'h50);
        chk("R2 readback", ctrl_q, 8'h76);
        clear_log();
        write_ctrl(8'h81);
        wait_idle();
        push(32'h300);
        compare_log("R11 abort held");
        chk("R11 bus freed", ext_status, 8'h40);
        chk("R11 count kept", xfer_cnt, 4);
    endtask

    task automatic t_read_stop_each();
        clear_log();
        write_ctrl(8'h1F);
        wait_idle();
        for (int b = 0; b < 2; b++) begin
            push(8'hA5); push(32'h200); push(32'h300);
        end
        compare_log("R5 stop each");
        chk("R4 rx byte1", rx_data[15:8], 8'h34);
        chk("R6 count two", xfer_cnt, 2);
    endtask

    task automatic t_addr_nack();
        clear_log();
        nack_at = 0;
        write_ctrl(8'h31);
        wait_idle();
        push(8'hA4);
        compare_log("R7 addr nack");
        chk("R7 err", err, 1);
        chk("R7 ext abort", ext_status, 8'h41);
        chk("R10 count zero", xfer_cnt, 0);
        nack_at = -1;
    endtask

    task automatic t_recover();
        clear_log();
        write_ctrl(8'h01);
        wait_idle();
        push(8'hA4); push(32'h111); push(32'h300);
        compare_log("R9 recover");
        chk("R9 err cleared", err, 0);
        chk("R9 abort sticky", ext_status, 8'h41);
        chk("R10 count one", xfer_cnt, 1);
    endtask

    task automatic t_data_nack();
        clear_log();
        nack_at = 4;
        write_ctrl(8'h31);
        wait_idle();
        push(8'hA4); push(32'h111); push(32'h300); push(8'hA4); push(32'h122);
        compare_log("R8 data nack");
        chk("R8 err", err, 1);
        chk("R8 held after nack", ext_status, 8'h51);
        chk("R8 count one", xfer_cnt, 1);
        nack_at = -1;
        clear_log();
        write_ctrl(8'h80);
        wait_idle();
        push(32'h300);
        compare_log("R11 abort stop");
    endtask

    task automatic t_busy_ignored();
        clear_log();
        write_ctrl(8'h01);
        repeat (2) @(negedge clk);
        write_ctrl(8'h37);
        wait_idle();
        push(8'hA4); push(32'h111); push(32'h300);
        compare_log("R12 busy write");
        chk("R12 ctrl_q", ctrl_q, 8'h00);
        chk("R12 count", xfer_cnt, 1);
    endtask

    task automatic t_abort_free();
        clear_log();
        write_ctrl(8'h80);
        repeat (10) @(negedge clk);
        chk("R11 no commands", lg_n, 0);
        chk("R11 idle", busy, 0);
        chk("R2 abort stored", ctrl_q, 8'h80);
    endtask

    task automatic t_wide_addr();
        clear_log();
        addr_reg = 8'h3B;
        write_ctrl(8'h41);
        wait_idle();
        push(8'h3A); push(32'h111); push(32'h300);
        compare_log("R3 wide bit ignored");
        addr_reg = 8'hA4;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_two();
        t_read_hold();
        t_read_stop_each();
        t_addr_nack();
        t_recover();
        t_data_nack();
        t_busy_ignored();
        t_abort_free();
        t_wide_addr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule